// File: doc/BRIEF.md
# Compare-and-Branch Resolution Unit

This unit decides conditional branches for a small 32-bit processor that does not keep condition flags. A compare instruction hands the unit two register values, which it stores unchanged as a pair of saved operands. A later conditional branch presents its 16-bit instruction word and its own program counter. The unit then evaluates the selected condition on the saved pair and returns whether the branch is taken and which address execution continues from.

The branch word carries a 4-bit condition select in bits 13:10 and a 10-bit signed halfword displacement in bits 9:0. Ten select codes are defined. The other six are reported as an illegal condition, and in that case the unit returns the faulting branch address so that the exception logic can record it. Results are registered and appear one clock after the branch strobe, qualified by a result-valid output.

Top module: `cbr_resolve`

## Requirements
- R1: When `cmp_load` is high at a clock edge, the saved operand pair becomes (`cmp_a_in`, `cmp_b_in`) unchanged, and later branches use these values. With `cmp_load` low, the saved pair keeps its value.
- R2: When a compare load and a branch fall on the same edge, that branch is evaluated against the pair saved before that edge. The next branch sees the new pair.
- R3: The displacement is `br_insn[9:0]`, sign-extended and multiplied by two. A taken branch sets `next_pc` = `br_pc` + 2 + displacement, with modulo 2^32 wrap.
- R4: A legal branch whose condition is false sets `next_pc` = `br_pc` + 2 and drives `br_taken` low.
- R5: Unsigned conditions compare saved A against saved B: code 4 is A<B, code 5 is A>B, code 8 is A>=B and code 9 is A<=B.
- R6: Signed (two's complement) conditions compare saved A against saved B: code 2 is A<B, code 3 is A>B, code 6 is A>=B and code 7 is A<=B.
- R7: Code 0 is taken when A==B, and code 1 is taken when A!=B.
- R8: Select codes 10 through 15 raise `bad_cond`, keep `br_taken` low and return the faulting `br_pc` on `next_pc`.
- R9: Results appear on the clock edge after the edge that samples `br_valid`, with `res_valid` high for exactly that cycle. In a cycle without a result, `res_valid`, `br_taken` and `bad_cond` are all low.
- R10: A synchronous active-low reset clears the saved pair to zero and drives `res_valid`, `br_taken`, `bad_cond` and `next_pc` to zero.
- R11: Instruction bits 15:14 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_load | input | 1 | Capture the compare operands at this edge |
| cmp_a_in | input | 32 | First compare operand |
| cmp_b_in | input | 32 | Second compare operand |
| br_valid | input | 1 | A branch is presented this cycle |
| br_insn | input | 16 | Branch instruction word |
| br_pc | input | 32 | Address of the branch instruction |
| res_valid | output | 1 | Result outputs are valid this cycle |
| br_taken | output | 1 | Branch condition held |
| bad_cond | output | 1 | Condition select was undefined |
| next_pc | output | 32 | Continuation address, or the faulting address when `bad_cond` is high |

## Verification
The bench builds the unit with its default parameters: 32-bit operands and addresses and a 10-bit displacement. With these widths, operands whose bit 31 is set can be chosen, so the signed and unsigned orderings of the same pair disagree. The displacements tested include the extremes +1022 and -1024 bytes and the -2 case that branches back to its own address. Every select code, legal or illegal, is applied from a known saved pair, including the case where a load and a branch fall on the same edge.

// File: rtl/cbr_pkg.sv
// Shared definitions for the compare-and-branch resolution unit.
// Assumes a 4-bit condition select. Codes at or above NUM_CONDS are undefined.
package cbr_pkg;

    typedef enum logic [3:0] {
        C_EQ  = 4'd0,
        C_NE  = 4'd1,
        C_LT  = 4'd2,
        C_GT  = 4'd3,
        C_LTU = 4'd4,
        C_GTU = 4'd5,
        C_GE  = 4'd6,
        C_LE  = 4'd7,
        C_GEU = 4'd8,
        C_LEU = 4'd9
    } cond_e;

    localparam int unsigned SEL_W     = 4;
    localparam int unsigned NUM_CONDS = 10;

endpackage

// File: rtl/cbr_cmp_regs.sv
// Saved compare operand pair.
// Captures both operands unchanged when load is high. Otherwise it holds them.
// Assumes a synchronous active-low reset that clears the pair to zero.
module cbr_cmp_regs #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] a_q,
    output logic [DATA_W-1:0] b_q
);

    // Hold or replace the saved operand pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (load) begin
            a_q <= a_in;
            b_q <= b_in;
        end
    end

endmodule

// File: rtl/cbr_cond_eval.sv
// Condition evaluator.
// Computes every defined condition on the saved pair in parallel, then selects
// the requested one. Assumes the select width given in cbr_pkg.
module cbr_cond_eval
    import cbr_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [SEL_W-1:0]  sel,
    output logic              hit,
    output logic              legal
);

    localparam int unsigned SEL_RANGE = 1 << SEL_W;

    // One condition, evaluated as a against b.
    function automatic logic cond_hit(input logic [SEL_W-1:0] code,
                                      input logic [DATA_W-1:0] x,
                                      input logic [DATA_W-1:0] y);
        logic r;
        case (cond_e'(code))
            C_EQ:    r = (x == y);
            C_NE:    r = (x != y);
            C_LT:    r = ($signed(x) <  $signed(y));
            C_GT:    r = ($signed(x) >  $signed(y));
            C_LTU:   r = (x <  y);
            C_GTU:   r = (x >  y);
            C_GE:    r = ($signed(x) >= $signed(y));
            C_LE:    r = ($signed(x) <= $signed(y));
            C_GEU:   r = (x >= y);
            C_LEU:   r = (x <= y);
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    logic [SEL_RANGE-1:0] hits;

    // One comparator per select code. Undefined codes produce a constant low.
    for (genvar g = 0; g < SEL_RANGE; g++) begin : g_cond
        if (g < NUM_CONDS) begin : g_def
            assign hits[g] = cond_hit(SEL_W'(g), a, b);
        end else begin : g_undef
            assign hits[g] = 1'b0;
        end
    end

    // Select the requested condition and flag an undefined select.
    always_comb begin
        legal = (32'(sel) < NUM_CONDS);
        hit   = hits[sel];
    end

endmodule

// File: rtl/cbr_target_gen.sv
// Branch address generator.
// Forms the sequential address (pc + instruction length) and the taken
// address (sequential + sign-extended halfword displacement * 2).
// Assumes ADDR_W > OFFS_W + 1.
module cbr_target_gen #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned OFFS_W    = 10,
    parameter int unsigned ILEN_BYTE = 2
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [OFFS_W-1:0] offs,
    output logic [ADDR_W-1:0] seq_pc,
    output logic [ADDR_W-1:0] tgt_pc
);

    localparam int unsigned EXT_W = ADDR_W - OFFS_W - 1;

    logic [ADDR_W-1:0] disp;

    // Sign-extend the halfword count and convert it to bytes.
    always_comb begin
        disp   = {{EXT_W{offs[OFFS_W-1]}}, offs, 1'b0};
        seq_pc = pc + ADDR_W'(ILEN_BYTE);
        tgt_pc = seq_pc + disp;
    end

endmodule

// File: rtl/cbr_resolve.sv
// Compare-and-branch resolution unit (top).
// Keeps the last compare operands and resolves a branch one clock after
// br_valid. next_pc carries the continuation address, or the faulting address
// for an undefined condition. Bits above the condition select are not decoded.
module cbr_resolve
    import cbr_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned INSN_W  = 16,
    parameter int unsigned OFFS_W  = 10,
    parameter int unsigned SEL_LSB = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_load,
    input  logic [DATA_W-1:0] cmp_a_in,
    input  logic [DATA_W-1:0] cmp_b_in,
    input  logic              br_valid,
    input  logic [INSN_W-1:0] br_insn,
    input  logic [ADDR_W-1:0] br_pc,
    output logic              res_valid,
    output logic              br_taken,
    output logic              bad_cond,
    output logic [ADDR_W-1:0] next_pc
);

    logic [DATA_W-1:0] cc_a;
    logic [DATA_W-1:0] cc_b;
    logic [SEL_W-1:0]  sel;
    logic [OFFS_W-1:0] offs;
    logic              hit;
    logic              legal;
    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] tgt_pc;

    // Split the instruction word into its select and displacement fields.
    always_comb begin
        sel  = br_insn[SEL_LSB +: SEL_W];
        offs = br_insn[OFFS_W-1:0];
    end

    cbr_cmp_regs #(.DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cmp_load),
        .a_in  (cmp_a_in),
        .b_in  (cmp_b_in),
        .a_q   (cc_a),
        .b_q   (cc_b)
    );

    cbr_cond_eval #(.DATA_W(DATA_W)) u_eval (
        .a     (cc_a),
        .b     (cc_b),
        .sel   (sel),
        .hit   (hit),
        .legal (legal)
    );

    cbr_target_gen #(
        .ADDR_W    (ADDR_W),
        .OFFS_W    (OFFS_W),
        .ILEN_BYTE (INSN_W / 8)
    ) u_tgt (
        .pc     (br_pc),
        .offs   (offs),
        .seq_pc (seq_pc),
        .tgt_pc (tgt_pc)
    );

    // Register the branch outcome one clock after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            br_taken  <= 1'b0;
            bad_cond  <= 1'b0;
            next_pc   <= '0;
        end else begin
            res_valid <= br_valid;
            if (br_valid && !legal) begin
                br_taken <= 1'b0;
                bad_cond <= 1'b1;
                next_pc  <= br_pc;
            end else if (br_valid) begin
                br_taken <= hit;
                bad_cond <= 1'b0;
                next_pc  <= hit ? tgt_pc : seq_pc;
            end else begin
                br_taken <= 1'b0;
                bad_cond <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cbr_resolve_chk.sv
// Property checker for cbr_resolve, attached by bind.
// Observes the ports and the saved operand pair. It drives nothing.
module cbr_resolve_chk #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned INSN_W  = 16,
    parameter int unsigned OFFS_W  = 10,
    parameter int unsigned SEL_LSB = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmp_load,
    input logic [DATA_W-1:0] cmp_a_in,
    input logic [DATA_W-1:0] cmp_b_in,
    input logic              br_valid,
    input logic [INSN_W-1:0] br_insn,
    input logic [ADDR_W-1:0] br_pc,
    input logic              res_valid,
    input logic              br_taken,
    input logic              bad_cond,
    input logic [ADDR_W-1:0] next_pc,
    input logic [DATA_W-1:0] cc_a,
    input logic [DATA_W-1:0] cc_b
);

    logic [3:0]        sel_w;
    logic              undef_w;
    logic [ADDR_W-1:0] disp_w;

    // Decode the fields independently of the design.
    always_comb begin
        sel_w   = br_insn[SEL_LSB +: 4];
        undef_w = (sel_w > 4'd9);
        disp_w  = ADDR_W'($signed(br_insn[OFFS_W-1:0])) << 1;
    end

    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_load |=> (cc_a == $past(cmp_a_in)) && (cc_b == $past(cmp_b_in)));

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_load |=> $stable(cc_a) && $stable(cc_b));

    p_taken_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !undef_w) |=>
            (!br_taken || next_pc == $past(br_pc) + ADDR_W'(2) + $past(disp_w)));

    p_fallthru_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !undef_w) |=>
            (br_taken || next_pc == $past(br_pc) + ADDR_W'(2)));

    p_equal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && sel_w == 4'd0) |=> (br_taken == ($past(cc_a) == $past(cc_b))));

    p_fault_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && undef_w) |=> bad_cond && !br_taken && (next_pc == $past(br_pc)));

    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> res_valid);

    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !br_taken && !bad_cond);

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({br_taken, bad_cond}) <= 1);

endmodule

bind cbr_resolve cbr_resolve_chk #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .INSN_W  (INSN_W),
    .OFFS_W  (OFFS_W),
    .SEL_LSB (SEL_LSB)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_load  (cmp_load),
    .cmp_a_in  (cmp_a_in),
    .cmp_b_in  (cmp_b_in),
    .br_valid  (br_valid),
    .br_insn   (br_insn),
    .br_pc     (br_pc),
    .res_valid (res_valid),
    .br_taken  (br_taken),
    .bad_cond  (bad_cond),
    .next_pc   (next_pc),
    .cc_a      (cc_a),
    .cc_b      (cc_b)
);

// File: tb/tb_cbr_resolve.sv
// Scoreboard bench for cbr_resolve: a driver queues expected results and a
// monitor pops and compares them when res_valid appears.
module tb_cbr_resolve;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_load = 1'b0;
    logic [31:0] cmp_a_in = '0;
    logic [31:0] cmp_b_in = '0;
    logic        br_valid = 1'b0;
    logic [15:0] br_insn = '0;
    logic [31:0] br_pc = '0;
    logic        res_valid;
    logic        br_taken;
    logic        bad_cond;
    logic [31:0] next_pc;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic        taken;
        logic        bad;
        logic [31:0] npc;
        string       req;
    } exp_t;

    exp_t sb[$];
    logic [31:0] ma = '0;
    logic [31:0] mb = '0;

    always #5 clk = ~clk;

    cbr_resolve dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_load  (cmp_load),
        .cmp_a_in  (cmp_a_in),
        .cmp_b_in  (cmp_b_in),
        .br_valid  (br_valid),
        .br_insn   (br_insn),
        .br_pc     (br_pc),
        .res_valid (res_valid),
        .br_taken  (br_taken),
        .bad_cond  (bad_cond),
        .next_pc   (next_pc)
    );

    // Reference condition from the requirement text.
    function automatic logic ref_cond(input logic [3:0] c, input logic [31:0] a,
                                      input logic [31:0] b);
        case (c)
            4'd0: return a == b;
            4'd1: return a != b;
            4'd2: return $signed(a) <  $signed(b);
            4'd3: return $signed(a) >  $signed(b);
            4'd4: return a <  b;
            4'd5: return a >  b;
            4'd6: return $signed(a) >= $signed(b);
            4'd7: return $signed(a) <= $signed(b);
            4'd8: return a >= b;
            4'd9: return a <= b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic exp_t predict(input logic [15:0] insn, input logic [31:0] pc,
                                     input string req);
        exp_t e;
        logic [3:0]  c;
        logic [31:0] d;
        c = insn[13:10];
        d = {{21{insn[9]}}, insn[9:0], 1'b0};
        e.req = req;
        if (c > 4'd9) begin
            e.taken = 1'b0; e.bad = 1'b1; e.npc = pc;
        end else begin
            e.bad = 1'b0;
            e.taken = ref_cond(c, ma, mb);
            e.npc = e.taken ? pc + 32'd2 + d : pc + 32'd2;
        end
        return e;
    endfunction

    function automatic logic [15:0] mk(input logic [1:0] top, input logic [3:0] c,
                                       input logic [9:0] off);
        return {top, c, off};
    endfunction

    task automatic do_load(input logic [31:0] a, input logic [31:0] b);
        cmp_load = 1'b1; cmp_a_in = a; cmp_b_in = b;
        @(negedge clk);
        cmp_load = 1'b0;
        ma = a; mb = b;
    endtask

    task automatic do_branch(input logic [15:0] insn, input logic [31:0] pc,
                             input string req);
        sb.push_back(predict(insn, pc, req));
        br_valid = 1'b1; br_insn = insn; br_pc = pc;
        @(negedge clk);
        br_valid = 1'b0;
    endtask

    task automatic do_both(input logic [31:0] a, input logic [31:0] b,
                           input logic [15:0] insn, input logic [31:0] pc, input string req);
        sb.push_back(predict(insn, pc, req));
        cmp_load = 1'b1; cmp_a_in = a; cmp_b_in = b;
        br_valid = 1'b1; br_insn = insn; br_pc = pc;
        @(negedge clk);
        cmp_load = 1'b0; br_valid = 1'b0;
        ma = a; mb = b;
    endtask

    // One idle cycle, then R9 quiet-output check.
    task automatic idle_check();
        @(negedge clk);
        checks++;
        if (res_valid || br_taken || bad_cond) begin
            fails++;
            $display("FAIL R9 idle: valid=%0b taken=%0b bad=%0b expected 0 0 0",
                     res_valid, br_taken, bad_cond);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        ma = '0; mb = '0;
    endtask

    // Monitor: pop and compare one expected item per result.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R9 unexpected result: taken=%0b npc=%h expected none",
                         br_taken, next_pc);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (br_taken !== e.taken || bad_cond !== e.bad || next_pc !== e.npc) begin
                    fails++;
                    $display("FAIL %s: taken=%0b bad=%0b npc=%h expected taken=%0b bad=%0b npc=%h",
                             e.req, br_taken, bad_cond, next_pc, e.taken, e.bad, e.npc);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R10: reset state of outputs.
        @(negedge clk);
        checks++;
        if (res_valid || br_taken || bad_cond || next_pc !== 32'd0) begin
            fails++;
            $display("FAIL R10 reset: valid=%0b taken=%0b bad=%0b npc=%h expected 0 0 0 0",
                     res_valid, br_taken, bad_cond, next_pc);
        end
        // R10: saved pair is zero, so equal taken and unsigned less-than not taken.
        do_branch(mk(2'b11, 4'd0, 10'd4), 32'h100, "R10 eq after reset");
        do_branch(mk(2'b11, 4'd4, 10'd4), 32'h100, "R10 ltu after reset");
        idle_check();

        // R5/R7: a=5, b=7.
        do_load(32'd5, 32'd7);
        do_branch(mk(2'b11, 4'd4, 10'd3), 32'h400, "R5 ltu");
        do_branch(mk(2'b11, 4'd5, 10'd3), 32'h400, "R5 gtu");
        do_branch(mk(2'b11, 4'd8, 10'd3), 32'h400, "R5 geu");
        do_branch(mk(2'b11, 4'd9, 10'd3), 32'h400, "R5 leu");
        do_branch(mk(2'b11, 4'd0, 10'd3), 32'h400, "R7 eq");
        do_branch(mk(2'b11, 4'd1, 10'd3), 32'h400, "R7 ne");

        // R6/R5: negative a against positive b, every code.
        do_load(32'hFFFF_FFF0, 32'd3);
        for (int c = 0; c < 10; c++)
            do_branch(mk(2'b11, 4'(c), 10'd16), 32'h800, "R6 R5 mixed-sign");

        // Equal pair, every code.
        do_load(32'h0000_1234, 32'h0000_1234);
        for (int c = 0; c < 10; c++)
            do_branch(mk(2'b11, 4'(c), 10'd8), 32'h900, "R7 R6 equal pair");

        // R3: displacement extremes with an always-true condition.
        do_branch(mk(2'b11, 4'd0, 10'h1FF), 32'h2000, "R3 max forward");
        do_branch(mk(2'b11, 4'd0, 10'h200), 32'h2000, "R3 max backward");
        do_branch(mk(2'b11, 4'd0, 10'h3FF), 32'h2000, "R3 minus one halfword");
        do_branch(mk(2'b11, 4'd0, 10'h001), 32'hFFFF_FFFC, "R3 wrap");
        // R4: false condition falls through.
        do_branch(mk(2'b11, 4'd1, 10'h1FF), 32'h2000, "R4 not taken");

        // R8: undefined selects.
        for (int c = 10; c < 16; c++)
            do_branch(mk(2'b11, 4'(c), 10'h155), 32'h3000 + 32'(c * 2), "R8 undefined");
        idle_check();

        // R11: top bits varied.
        do_load(32'd1, 32'd2);
        do_branch(mk(2'b00, 4'd4, 10'd10), 32'h5000, "R11 top 00");
        do_branch(mk(2'b01, 4'd4, 10'd10), 32'h5000, "R11 top 01");
        do_branch(mk(2'b10, 4'd5, 10'd10), 32'h5000, "R11 top 10");

        // R2: load and branch on the same edge use the old pair, then the new one.
        do_both(32'd9, 32'd2, mk(2'b11, 4'd4, 10'd6), 32'h6000, "R2 same edge old pair");
        do_branch(mk(2'b11, 4'd4, 10'd6), 32'h6000, "R2 next sees new pair");
        // R1: pair held across idle cycles.
        idle_check();
        idle_check();
        do_branch(mk(2'b11, 4'd5, 10'd6), 32'h6010, "R1 pair held");

        // R10: mid-run reset clears the pair.
        idle_check();
        do_reset();
        do_branch(mk(2'b11, 4'd0, 10'd2), 32'h7000, "R10 pair cleared");
        idle_check();

        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R9 missing results: %0d pending expected 0", sb.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule